// File: doc/BRIEF.md
# Bi-phase Line Clock and Data Recovery

This block recovers bit timing and data from a serial line that carries bi-phase space (FM0) or bi-phase mark (FM1) coding. Both codes put a transition at the start of every bit cell. They differ in what a transition in the middle of the cell means. In FM0 a transition there marks a zero. In FM1 it marks a one. A digital phase-locked loop runs a 16-count phase counter per bit cell. It sorts each line transition into a boundary window or a mid-cell window and nudges the counter by one count whenever a boundary transition comes early or late. The block emits one recovered bit per cell, together with a one-clock valid strobe.

The phase counter advances on a local tick that runs at sixteen times the bit rate. The tick comes in one of two ways. In direct mode, every system clock is a tick. In divided mode, a prescaler fires once every N clocks, and N is never less than four. With the prescaler in use, the clock must therefore run at 64 or more times the bit rate.

The loop starts out hunting. In the hunting state, every transition restarts the cell timing. The loop declares lock after a run of four identical decoded bits: ones in FM0, zeros in FM1. Lock is lost as soon as a cell ends without a boundary transition. A consequence follows from these two rules. An idle line of 0x7E flags brings FM0 into lock, but FM1 can never lock on that idle pattern alone. Framing, zero-bit removal and CRC belong to the layer above.

Top module: `biphase_dpll`

## Requirements
- R1: After reset, `in_sync`, `bit_valid` and `rx_bit` are 0, the phase counter is 0, and the stored line level is 0.
- R2: With `use_div`=0, every clock is a phase tick. With `use_div`=1, a tick fires once every max(`div_ratio`,4) clocks, so ratios 0 to 3 behave as 4.
- R3: On a tick where the line differs from its level at the previous tick, an edge is seen at phase count P (0..15). P in 4..11 is a mid-cell edge, and any other P is a boundary edge. While locked, a boundary edge at P in 12..15 advances the counter by two, a boundary edge at P in 1..3 holds it for one tick, and every other tick advances it by one (modulo 16).
- R4: While not locked, any edge sets the next phase to 1, so the edge itself counts as phase 0. It marks a boundary as seen and discards any mid-cell edge recorded so far. If the edge lies in 4..11, it also clears the lock run count, and that tick makes no decision.
- R5: On a tick at phase 11 that carries no hunting edge, the block makes a cell decision. If a boundary edge has been seen since the last decision, `bit_valid` pulses for one clock and `rx_bit` takes the decoded value. With `fm_mode`=0 (FM0) the value is 1 when no mid-cell edge was seen. With `fm_mode`=1 (FM1) the value is 1 when a mid-cell edge was seen, and an edge at phase 11 counts as mid-cell.
- R6: `in_sync` rises at the decision that completes four consecutive decoded bits of value 1 in FM0, or of value 0 in FM1. A decoded bit of the other value resets the run count.
- R7: A decision with no boundary edge seen produces no strobe and clears both `in_sync` and the run count.
- R8: A line idling on 0x7E flags, sent least significant bit first, brings FM0 into lock but leaves FM1 unlocked.
- R9: `bit_valid` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; in direct mode it is the 16x sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_div | input | 1 | 1 selects the prescaled tick, 0 uses every clock |
| div_ratio | input | DIV_W (8) | Prescaler divide ratio; values below 4 act as 4 |
| fm_mode | input | 1 | 0 selects FM0, 1 selects FM1 |
| line_in | input | 1 | Encoded serial line, already synchronous to clk |
| rx_bit | output | 1 | Most recently decoded bit |
| bit_valid | output | 1 | One-clock strobe for a new decoded bit |
| in_sync | output | 1 | Loop is locked to the cell timing |

## Verification
The bench builds the block with its default 8-bit divide-ratio width and a run length of four. This allows direct mode and divided mode to be compared side by side. In divided mode, ratios of 2 and 6 exercise both the clamp to four and a ratio above the minimum. Cells stretched to 17 ticks and shrunk to 15 ticks drive the early and late correction paths while the loop stays locked. A held line drives the loss path. Idle flags in both codes expose the asymmetry in lock behaviour between FM0 and FM1.

// File: rtl/bdpll_pkg.sv
package bdpll_pkg;
  localparam int CELL_TICKS = 16;
  localparam int PH_W       = $clog2(CELL_TICKS);
  localparam int MID_LO     = CELL_TICKS / 4;
  localparam int DECIDE_PH  = CELL_TICKS - 5;
  localparam int MIN_DIV    = 4;

  typedef enum logic {
    ENC_FM0 = 1'b0,
    ENC_FM1 = 1'b1
  } enc_e;

  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/bdpll_prescale.sv
module bdpll_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_div,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             tick
);
  import bdpll_pkg::*;

  logic [DIV_W-1:0] cnt_q, cnt_d, last_cnt;
  logic             wrap;

  always_comb begin
    if (div_ratio < DIV_W'(MIN_DIV)) last_cnt = DIV_W'(MIN_DIV - 1);
    else                             last_cnt = div_ratio - DIV_W'(1);
    wrap = (cnt_q >= last_cnt);
    tick = use_div ? wrap : 1'b1;
    if (!use_div || wrap) cnt_d = '0;
    else                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bdpll_phase.sv
module bdpll_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  input  logic hunt,
  output logic edge_mid,
  output logic edge_bnd,
  output logic snap,
  output logic decide
);
  import bdpll_pkg::*;

  phase_t ph_q, ph_d;
  logic   line_q, line_d;
  logic   edge_now, in_mid;

  always_comb begin
    edge_now = tick && (line_in != line_q);
    in_mid   = (ph_q >= PH_W'(MID_LO)) && (ph_q <= PH_W'(DECIDE_PH));
    edge_mid = edge_now && in_mid;
    edge_bnd = edge_now && !in_mid;
    snap     = edge_now && hunt;
    decide   = tick && !snap && (ph_q == PH_W'(DECIDE_PH));
    line_d   = tick ? line_in : line_q;
    if (!tick)                                     ph_d = ph_q;
    else if (snap)                                 ph_d = PH_W'(1);
    else if (edge_bnd && ph_q > PH_W'(DECIDE_PH))  ph_d = ph_q + PH_W'(2);
    else if (edge_bnd && ph_q != '0)               ph_d = ph_q;
    else                                           ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      line_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/bdpll_decide.sv
module bdpll_decide #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fm_mode,
  input  logic edge_mid,
  input  logic edge_bnd,
  input  logic snap,
  input  logic decide,
  output logic rx_bit,
  output logic bit_valid,
  output logic in_sync
);
  import bdpll_pkg::*;

  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic             mid_q, mid_d, bnd_q, bnd_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             sync_d, bit_d, valid_d;
  logic             bit_now, target, mid_any;

  always_comb begin
    mid_any = mid_q || edge_mid;
    bit_now = (enc_e'(fm_mode) == ENC_FM1) ? mid_any : !mid_any;
    target  = (enc_e'(fm_mode) == ENC_FM0);
    mid_d   = mid_q;
    bnd_d   = bnd_q;
    run_d   = run_q;
    sync_d  = in_sync;
    bit_d   = rx_bit;
    valid_d = 1'b0;
    if (snap) begin
      bnd_d = 1'b1;
      mid_d = 1'b0;
      if (edge_mid) run_d = '0;
    end else begin
      if (edge_mid) mid_d = 1'b1;
      if (edge_bnd) bnd_d = 1'b1;
      if (decide) begin
        mid_d = 1'b0;
        bnd_d = 1'b0;
        if (bnd_q) begin
          valid_d = 1'b1;
          bit_d   = bit_now;
          if (bit_now == target) begin
            if (run_q != RUN_W'(RUN_LEN))     run_d  = run_q + RUN_W'(1);
            if (run_q >= RUN_W'(RUN_LEN - 1)) sync_d = 1'b1;
          end else begin
            run_d = '0;
          end
        end else begin
          sync_d = 1'b0;
          run_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q     <= 1'b0;
      bnd_q     <= 1'b0;
      run_q     <= '0;
      in_sync   <= 1'b0;
      rx_bit    <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      mid_q     <= mid_d;
      bnd_q     <= bnd_d;
      run_q     <= run_d;
      in_sync   <= sync_d;
      rx_bit    <= bit_d;
      bit_valid <= valid_d;
    end
  end
endmodule

// File: rtl/biphase_dpll.sv
module biphase_dpll #(
  parameter int DIV_W   = 8,
  parameter int RUN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_div,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             fm_mode,
  input  logic             line_in,
  output logic             rx_bit,
  output logic             bit_valid,
  output logic             in_sync
);
  logic tick, edge_mid, edge_bnd, snap, decide;

  bdpll_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .use_div(use_div), .div_ratio(div_ratio), .tick(tick)
  );

  bdpll_phase u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in), .hunt(!in_sync),
    .edge_mid(edge_mid), .edge_bnd(edge_bnd), .snap(snap), .decide(decide)
  );

  bdpll_decide #(.RUN_LEN(RUN_LEN)) u_decide (
    .clk(clk), .rst_n(rst_n), .fm_mode(fm_mode), .edge_mid(edge_mid),
    .edge_bnd(edge_bnd), .snap(snap), .decide(decide),
    .rx_bit(rx_bit), .bit_valid(bit_valid), .in_sync(in_sync)
  );
endmodule

// File: rtl/bdpll_checker.sv
module bdpll_checker (
  input logic clk,
  input logic rst_n,
  input logic use_div,
  input logic tick,
  input logic fm_mode,
  input logic rx_bit,
  input logic bit_valid,
  input logic in_sync
);
  // R1: state right after reset release
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bit_valid && !in_sync));

  // R2: divided ticks never fire on back-to-back clocks
  assert_div_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_div && tick) |=> (!use_div || !tick));

  // R5: a strobe follows a tick
  assert_strobe_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(tick));

  // R6: lock arrives together with a strobe of the lock-run value
  assert_lock_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> (bit_valid && (rx_bit == !$past(fm_mode))));

  // R7: losing lock produces no strobe
  assert_loss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> !bit_valid);

  // R9: one-clock strobe
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
endmodule

bind biphase_dpll bdpll_checker u_bdpll_chk (
  .clk(clk), .rst_n(rst_n), .use_div(use_div), .tick(tick), .fm_mode(fm_mode),
  .rx_bit(rx_bit), .bit_valid(bit_valid), .in_sync(in_sync)
);

// File: tb/biphase_dpll_bench.sv
module biphase_dpll_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       use_div;
  logic [7:0] div_ratio;
  logic       fm_mode;
  logic       line_in;
  logic       rx_bit, bit_valid, in_sync;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  bit cap_on = 0;
  bit exp_q[$];
  bit got_q[$];

  always #2 clk = ~clk;

  biphase_dpll u_biphase_dpll (
    .clk(clk), .rst_n(rst_n), .use_div(use_div), .div_ratio(div_ratio),
    .fm_mode(fm_mode), .line_in(line_in),
    .rx_bit(rx_bit), .bit_valid(bit_valid), .in_sync(in_sync)
  );

  // behavioural reference model
  int m_pc, m_ph, m_run, m_lim;
  bit m_line, m_mseen, m_bseen, m_sync, m_bit, m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_ph = 0; m_run = 0; m_line = 0;
      m_mseen = 0; m_bseen = 0; m_sync = 0; m_bit = 0; m_valid = 0;
    end else begin
      bit tk, ed, mid, bnd, bv;
      m_valid = 0;
      tk = 0;
      if (!use_div) begin
        tk = 1; m_pc = 0;
      end else begin
        m_lim = (div_ratio < 4) ? 4 : int'(div_ratio);
        if (m_pc >= m_lim - 1) begin tk = 1; m_pc = 0; end
        else m_pc = m_pc + 1;
      end
      if (tk) begin
        ed  = (line_in != m_line);
        m_line = line_in;
        mid = ed && (m_ph >= 4) && (m_ph <= 11);
        bnd = ed && !mid;
        if (ed && !m_sync) begin
          if (mid) m_run = 0;
          m_ph = 1; m_bseen = 1; m_mseen = 0;
        end else begin
          if (mid) m_mseen = 1;
          if (bnd) m_bseen = 1;
          if (m_ph == 11) begin
            if (m_bseen) begin
              bv = fm_mode ? m_mseen : !m_mseen;
              m_bit = bv; m_valid = 1;
              if (bv == !fm_mode) begin
                if (m_run < 4) m_run = m_run + 1;
                if (m_run >= 4) m_sync = 1;
              end else m_run = 0;
            end else begin
              m_sync = 0; m_run = 0;
            end
            m_bseen = 0; m_mseen = 0;
          end
          if (bnd && m_ph >= 12)                  m_ph = (m_ph + 2) % 16;
          else if (bnd && m_ph >= 1 && m_ph <= 3) m_ph = m_ph;
          else                                    m_ph = (m_ph + 1) % 16;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the model, plus capture
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R5", "bit_valid vs model", {31'b0, bit_valid}, {31'b0, m_valid});
      if (m_valid) chk("R5", "rx_bit vs model", {31'b0, rx_bit}, {31'b0, m_bit});
      chk("R6", "in_sync vs model", {31'b0, in_sync}, {31'b0, m_sync});
      if (cap_on && bit_valid) got_q.push_back(rx_bit);
    end
  end

  task automatic do_reset();
    rst_n = 0; line_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int h1, input int h2);
    bit mid_flip;
    mid_flip = fm_mode ? b : !b;
    if (cap_on) exp_q.push_back(b);
    line_in = ~line_in;
    repeat (h1) @(negedge clk);
    if (mid_flip) line_in = ~line_in;
    repeat (h2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int h);
    for (int i = 0; i < 8; i++) send_bit(v[i], h, h);
  endtask

  task automatic cap_start();
    exp_q.delete(); got_q.delete(); cap_on = 1;
  endtask

  task automatic cap_stop(input string tag);
    cap_on = 0;
    chk(tag, "decoded bit count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        chk(tag, "decoded bit", {31'b0, got_q[i]}, {31'b0, exp_q[i]});
  endtask

  initial begin
    rst_n = 0; use_div = 0; div_ratio = 8'd4; fm_mode = 0; line_in = 0;
    do_reset();
    chk("R1", "in_sync after reset", {31'b0, in_sync}, 0);
    chk("R1", "bit_valid after reset", {31'b0, bit_valid}, 0);
    chk("R1", "rx_bit after reset", {31'b0, rx_bit}, 0);

    // FM0 lock on idle flags and data decode
    repeat (3) send_byte(8'h7E, 8);
    chk("R8", "FM0 locked by flags", {31'b0, in_sync}, 1);
    cap_start(); send_byte(8'hA5, 8); send_byte(8'h3C, 8); cap_stop("R5");

    // drifted cells: 15 and 17 ticks
    cap_start();
    for (int i = 0; i < 16; i++) send_bit(i[0] ^ i[2], 8, (i % 2 == 0) ? 7 : 9);
    cap_stop("R3");
    chk("R3", "lock kept under drift", {31'b0, in_sync}, 1);

    // missing boundary
    cap_start(); exp_q.delete();
    repeat (40) @(negedge clk);
    cap_on = 0;
    chk("R7", "lock dropped on held line", {31'b0, in_sync}, 0);
    chk("R7", "no strobe on held line", got_q.size(), 0);

    // hunting: a zero breaks the run of ones
    do_reset();
    send_bit(1, 8, 8); send_bit(1, 8, 8); send_bit(1, 8, 8);
    send_bit(0, 8, 8);
    send_bit(1, 8, 8); send_bit(1, 8, 8); send_bit(1, 8, 8);
    chk("R4", "run restarted by mid edge", {31'b0, in_sync}, 0);
    send_bit(1, 8, 8);
    chk("R6", "four ones lock FM0", {31'b0, in_sync}, 1);

    // FM1: flags do not lock, zeros do
    do_reset(); fm_mode = 1;
    repeat (4) send_byte(8'h7E, 8);
    chk("R8", "FM1 not locked by flags", {31'b0, in_sync}, 0);
    send_byte(8'h00, 8);
    chk("R6", "zeros lock FM1", {31'b0, in_sync}, 1);
    cap_start(); send_byte(8'h5A, 8); send_byte(8'h81, 8); cap_stop("R5");

    // prescaler, ratio clamped to four
    do_reset(); fm_mode = 0; use_div = 1; div_ratio = 8'd2;
    repeat (2) send_byte(8'h7E, 32);
    chk("R2", "lock with clamped divider", {31'b0, in_sync}, 1);
    cap_start(); send_byte(8'hC3, 32); cap_stop("R2");

    // prescaler, ratio six
    do_reset(); div_ratio = 8'd6;
    repeat (2) send_byte(8'h7E, 48);
    chk("R2", "lock with divide by six", {31'b0, in_sync}, 1);
    cap_start(); send_byte(8'h69, 48); cap_stop("R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule